// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block accepts three kinds of reset request and turns them into two reset outputs. The requests are a power-on request (`por_n`, active low), a rising edge on an asynchronous host reset pin, and a single-cycle watchdog pulse. The full reset (`full_rst`) goes to registers that only a power-on or watchdog reset may clear, such as clock-generator and port configuration settings. The general reset (`gen_rst`) goes to all other logic. Reset classes are power-on, watchdog and warm. Power-on and watchdog resets both last `COLD_LEN` cycles and both assert the full reset. Only a power-on reset re-captures the configuration straps.

The straps are a two-bit environment code and an option field. The sequencer holds them in registers and presents them to the rest of the chip. The environment code is decoded into a one-hot mode select plus an error flag for the illegal code. Host accesses are held off through `host_rdy` when the latched stall-option strap asks for it. The host bus side is kept disabled while the host reset pin is still high.

Top module: `reset_arbiter`

## Requirements
- R1: While `por_n` is low, `gen_rst` and `full_rst` are high and `rst_done` is low. After `por_n` rises, the power-on reset continues until `COLD_LEN` (default 64) rising clock edges have been seen with `clk_stable` high. Edges with `clk_stable` low are not counted.
- R2: When `rst_done` is high, a rising edge on `host_rst_pin` starts a warm reset. It passes through a two-flop synchroniser before edge detection. `gen_rst` is then high for exactly `WARM_LEN` (default 16) cycles and `full_rst` stays low.
- R3: A rising edge on `host_rst_pin`, or a level already high, that falls while any reset is in progress never starts a warm reset later.
- R4: A `wdog_req` pulse while no reset is active asserts both `gen_rst` and `full_rst` for `COLD_LEN` cycles.
- R5: A `wdog_req` pulse during a warm reset upgrades it. From the next cycle `full_rst` is high for `COLD_LEN` cycles, and `gen_rst` stays high continuously until then.
- R6: A `wdog_req` pulse during a power-on or watchdog reset is absorbed. It does not lengthen that reset.
- R7: `strap_env` and `strap_opt` are captured only during a power-on reset. `env_sel`, `env_err` and `strap_opts` keep their values through warm and watchdog resets, whatever the strap inputs do.
- R8: The latched environment code decodes as 00 -> `env_sel`=001, 01 -> 010, 10 -> 100. Code 11 gives `env_sel`=000 with `env_err`=1. `env_err` is 0 otherwise.
- R9: Latched option bit 1 is the stall strap. When it is 0, `host_rdy` is low whenever a reset is active and high otherwise. When it is 1, `host_rdy` is high once that strap value has been captured.
- R10: `host_if_en` is high only when no reset is active and the synchronised host reset pin is low.
- R11: `rst_done` is high exactly when `gen_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| clk_stable | input | 1 | Clock-stable flag gating the power-on count |
| host_rst_pin | input | 1 | Asynchronous host reset pin, rising edge starts warm reset |
| wdog_req | input | 1 | Single-cycle watchdog reset request |
| strap_env | input | 2 | Environment strap code |
| strap_opt | input | OPT_W | Option straps; bit 1 selects host stalling |
| full_rst | output | 1 | Reset for power-on/watchdog-only registers |
| gen_rst | output | 1 | Reset for all other logic |
| rst_done | output | 1 | High when no reset sequence is active |
| host_rdy | output | 1 | Host ready; low stalls host accesses |
| host_if_en | output | 1 | Host bus interface enable |
| env_sel | output | 3 | One-hot decoded environment mode |
| env_err | output | 1 | Illegal environment code latched |
| strap_opts | output | OPT_W | Latched option straps |

## Verification
A corrupted state or counter in this sequencer shows up as a reset pulse of the wrong length or of the wrong class. The scoreboard measures each `gen_rst` pulse and the number of `full_rst` cycles inside it, so the error is caught at the falling edge of the affected pulse. A spurious warm reset caused by a badly handled host edge, or a missed watchdog upgrade, leaves an unexpected or missing pulse in the record. That fault is reported at the next pop, or at the end-of-run check that the queue is empty. A strap register written at the wrong time changes `env_sel` or `strap_opts` at once, and the next strap check after a warm or watchdog reset exposes it.

// File: rtl/reset_arbiter.sv
module reset_arbiter #(
  parameter int COLD_LEN  = 64,
  parameter int WARM_LEN  = 16,
  parameter int OPT_W     = 4,
  parameter int STALL_BIT = 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clk_stable,
  input  logic             host_rst_pin,
  input  logic             wdog_req,
  input  logic [1:0]       strap_env,
  input  logic [OPT_W-1:0] strap_opt,
  output logic             full_rst,
  output logic             gen_rst,
  output logic             rst_done,
  output logic             host_rdy,
  output logic             host_if_en,
  output logic [2:0]       env_sel,
  output logic             env_err,
  output logic [OPT_W-1:0] strap_opts
);
  localparam int MAXLEN = (COLD_LEN > WARM_LEN) ? COLD_LEN : WARM_LEN;
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] COLD_LAST = CW'(COLD_LEN - 1);
  localparam logic [CW-1:0] WARM_LAST = CW'(WARM_LEN - 1);

  typedef enum logic [1:0] {S_RUN, S_COLD, S_WDOG, S_WARM} st_t;

  st_t             st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [2:0]      sync;
  logic [1:0]      env_q;
  logic [OPT_W-1:0] opt_q;
  logic            host_rise;

  assign host_rise = sync[1] & ~sync[2];

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      S_COLD: if (clk_stable) begin
        if (cnt == COLD_LAST) begin st_n = S_RUN; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      S_WDOG: begin
        if (cnt == COLD_LAST) begin st_n = S_RUN; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      S_WARM: begin
        if (wdog_req) begin st_n = S_WDOG; cnt_n = '0; end
        else if (cnt == WARM_LAST) begin st_n = S_RUN; cnt_n = '0; end
        else cnt_n = cnt + 1'b1;
      end
      default: begin
        if (wdog_req) begin st_n = S_WDOG; cnt_n = '0; end
        else if (host_rise) begin st_n = S_WARM; cnt_n = '0; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= S_COLD;
      cnt      <= '0;
      sync     <= '0;
      env_q    <= '0;
      opt_q    <= '0;
      full_rst <= 1'b1;
      gen_rst  <= 1'b1;
      rst_done <= 1'b0;
    end else begin
      sync     <= {sync[1:0], host_rst_pin};
      st       <= st_n;
      cnt      <= cnt_n;
      full_rst <= (st_n == S_COLD) || (st_n == S_WDOG);
      gen_rst  <= (st_n != S_RUN);
      rst_done <= (st_n == S_RUN);
      if (st == S_COLD) begin
        env_q <= strap_env;
        opt_q <= strap_opt;
      end
    end
  end

  assign host_rdy   = rst_done | opt_q[STALL_BIT];
  assign host_if_en = rst_done & ~sync[1];
  assign env_err    = (env_q == 2'b11);
  assign env_sel    = env_err ? 3'b000 : (3'b001 << env_q);
  assign strap_opts = opt_q;

  // R1
  full_in_gen_chk: assert property (@(posedge clk) disable iff (!por_n)
    full_rst |-> gen_rst);
  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_done != gen_rst);
  // R2
  warm_no_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_WARM) |-> !full_rst);
  // R7
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st != S_COLD) |=> ($stable(opt_q) && $stable(env_q)));
  // R8
  env_code_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(env_sel) && (env_err == (env_sel == 3'b000)));
  // R9
  stall_rdy_chk: assert property (@(posedge clk) disable iff (!por_n)
    (gen_rst && !opt_q[STALL_BIT]) |-> !host_rdy);
  // R6
  wdog_absorb_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_WDOG && wdog_req && cnt != COLD_LAST) |=> (cnt == $past(cnt) + 1'b1));
  // R10
  host_if_chk: assert property (@(posedge clk) disable iff (!por_n)
    host_if_en |-> (!gen_rst && !sync[1]));
endmodule

// File: tb/reset_arbiter_tb_top.sv
`timescale 1ns/1ps
module reset_arbiter_tb_top;
  localparam int COLD = 64;
  localparam int WARM = 16;

  logic clk = 1'b0;
  logic por_n, clk_stable, host_rst_pin, wdog_req;
  logic [1:0] strap_env;
  logic [3:0] strap_opt;
  logic full_rst, gen_rst, rst_done, host_rdy, host_if_en, env_err;
  logic [2:0] env_sel;
  logic [3:0] strap_opts;

  always #2 clk = ~clk;

  reset_arbiter #(.COLD_LEN(COLD), .WARM_LEN(WARM), .OPT_W(4), .STALL_BIT(1)) dut_i (
    .clk(clk), .por_n(por_n), .clk_stable(clk_stable), .host_rst_pin(host_rst_pin),
    .wdog_req(wdog_req), .strap_env(strap_env), .strap_opt(strap_opt),
    .full_rst(full_rst), .gen_rst(gen_rst), .rst_done(rst_done), .host_rdy(host_rdy),
    .host_if_en(host_if_en), .env_sel(env_sel), .env_err(env_err), .strap_opts(strap_opts));

  typedef struct { int g; int f; string r; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit mon_en = 0;
  int glen = 0, flen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int g, input int f, input string r);
    exp_t e;
    e.g = g; e.f = f; e.r = r;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!mon_en) begin
      glen = 0; flen = 0;
    end else if (gen_rst) begin
      glen++;
      if (full_rst) flen++;
    end else if (glen != 0) begin
      if (q.size() == 0) chk(0, "R3 unexpected reset pulse", glen, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(glen == e.g, {e.r, " gen length"}, glen, e.g);
        chk(flen == e.f, {e.r, " full length"}, flen, e.f);
      end
      glen = 0; flen = 0;
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!rst_done) @(negedge clk);
  endtask

  task automatic pulse_wdog();
    wdog_req = 1'b1;
    @(negedge clk);
    wdog_req = 1'b0;
  endtask

  task automatic do_cold(input logic [1:0] env, input logic [3:0] opt);
    mon_en = 0;
    @(negedge clk);
    strap_env = env; strap_opt = opt;
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    wait_done();
    repeat (2) @(negedge clk);
    mon_en = 1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int k;
    por_n = 1'b0; clk_stable = 1'b0; host_rst_pin = 1'b1; wdog_req = 1'b0;
    strap_env = 2'b01; strap_opt = 4'b0000;
    repeat (3) @(negedge clk);
    // reset state, R1 / R9
    chk(gen_rst == 1, "R1 gen in por", gen_rst, 1);
    chk(full_rst == 1, "R1 full in por", full_rst, 1);
    chk(rst_done == 0, "R11 done in por", rst_done, 0);
    chk(host_rdy == 0, "R9 host stalled", host_rdy, 0);
    por_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(gen_rst == 1, "R1 held without clk_stable", gen_rst, 1);
    clk_stable = 1'b1;
    k = 0;
    while (!rst_done && k < 1000) begin
      @(negedge clk); k++;
    end
    chk(k == COLD, "R1 cold length", k, COLD);
    chk(full_rst == 0, "R1 full released", full_rst, 0);
    // R3: pin held high through cold never starts a warm reset
    repeat (30) @(negedge clk);
    chk(gen_rst == 0, "R3 no warm after cold", gen_rst, 0);
    chk(host_if_en == 0, "R10 if off while pin high", host_if_en, 0);
    chk(host_rdy == 1, "R9 ready after reset", host_rdy, 1);
    chk(env_sel == 3'b010, "R8 env 01", env_sel, 3'b010);
    chk(env_err == 0, "R8 no err", env_err, 0);
    host_rst_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk(host_if_en == 1, "R10 if on", host_if_en, 1);
    mon_en = 1;

    // R2 warm reset, straps moved (R7)
    strap_env = 2'b10; strap_opt = 4'b1111;
    push(WARM, 0, "R2");
    host_rst_pin = 1'b1;
    @(negedge clk);
    while (!gen_rst) @(negedge clk);
    chk(host_rdy == 0, "R9 stalled in warm", host_rdy, 0);
    wait_done();
    @(negedge clk);
    chk(host_if_en == 0, "R10 pin still high", host_if_en, 0);
    chk(env_sel == 3'b010, "R7 env kept after warm", env_sel, 3'b010);
    chk(strap_opts == 4'b0000, "R7 opts kept after warm", strap_opts, 0);
    host_rst_pin = 1'b0;
    repeat (5) @(negedge clk);

    // R4 watchdog from idle
    push(COLD, COLD, "R4");
    pulse_wdog();
    wait_done();
    repeat (3) @(negedge clk);
    chk(strap_opts == 4'b0000, "R7 opts kept after wdog", strap_opts, 0);

    // R5 watchdog upgrades warm
    push(6 + COLD, COLD, "R5");
    host_rst_pin = 1'b1;
    @(negedge clk);
    while (!gen_rst) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_wdog();
    host_rst_pin = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);

    // R6 absorbed watchdog, R3 host edge during watchdog
    push(COLD, COLD, "R6");
    pulse_wdog();
    repeat (10) @(negedge clk);
    pulse_wdog();
    host_rst_pin = 1'b1;
    wait_done();
    repeat (20) @(negedge clk);
    chk(gen_rst == 0, "R3 no warm after wdog", gen_rst, 0);
    host_rst_pin = 1'b0;
    repeat (5) @(negedge clk);

    // R7/R8/R9 new cold captures straps
    do_cold(2'b11, 4'b0010);
    chk(env_err == 1, "R8 illegal code", env_err, 1);
    chk(env_sel == 3'b000, "R8 illegal sel", env_sel, 0);
    chk(strap_opts == 4'b0010, "R7 opts captured", strap_opts, 4'b0010);
    push(WARM, 0, "R2");
    host_rst_pin = 1'b1;
    @(negedge clk);
    while (!gen_rst) @(negedge clk);
    chk(host_rdy == 1, "R9 no stall strap", host_rdy, 1);
    host_rst_pin = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);

    do_cold(2'b00, 4'b0000);
    chk(env_sel == 3'b001, "R8 env 00", env_sel, 3'b001);
    do_cold(2'b10, 4'b0000);
    chk(env_sel == 3'b100, "R8 env 10", env_sel, 3'b100);
    chk(q.size() == 0, "R6 pending expected pulses", q.size(), 0);
    summary();
  end
endmodule